// File: doc/BRIEF.md
# Cascaded Bit-Slice Magnitude Comparator

This block compares two unsigned operands of a parameterised width and reports whether the first is greater than, less than or equal to the second. It is purely combinational. It is built as a chain of identical one-bit comparison cells. Each cell receives a three-flag relation from the cell one position lower, plus one bit of each operand, and passes an updated relation to the cell above.

The chain starts below bit 0 with a fixed "equal" relation. When a cell sees differing operand bits, it replaces the incoming relation with its own verdict. When the bits match, it forwards the relation unchanged. The top cell's relation therefore reflects the most significant bit position where the operands differ. It drives the three outputs, and exactly one of them is high.

Top module: `mag_cmp_casc`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i` > `b_i`, with both operands read as unsigned integers.
- R2: `lt_o` is 1 exactly when `a_i` < `b_i`, with both operands read as unsigned integers.
- R3: `eq_o` is 1 exactly when `a_i` == `b_i`.
- R4: Exactly one of `gt_o`, `lt_o`, `eq_o` is 1 for every operand pair.
- R5: The highest bit position where the operands differ alone decides the result, regardless of all lower bits (for example 4'b1000 versus 4'b0111 gives `gt_o`).
- R6: When no bit differs, the result is the chain seed: `eq_o`=1 with `gt_o`=`lt_o`=0. This holds for all-zero and for all-one operands.
- R7: Once a higher bit differs, changing any bits below that position in either operand leaves the outputs unchanged.
- R8: R1 to R4 hold for any `WIDTH`, including the default of 8, a narrow width of 4 and a wide width of 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| gt_o | output | 1 | a_i greater than b_i |
| lt_o | output | 1 | a_i less than b_i |
| eq_o | output | 1 | a_i equal to b_i |

## Verification
At a width of 4, every operand pair is applied. This separates the three relations at every possible position of the deciding bit, and confirms that the flags never overlap. At a width of 16, a table of hand-picked pairs covers several cases: all-zero and all-one operands, pairs that differ only in the MSB or only in the LSB, and near-miss pairs such as 0x8000 versus 0x7FFF. Together these show whether the top differing bit really overrides the lower ones. Random 16-bit pairs follow. A final pass keeps the MSB difference fixed while the lower bits are scrambled, which shows whether lower cells leak into a decided result.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } rel_t;

  localparam rel_t REL_SEED = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
endpackage

// File: rtl/mag_cmp_cell.sv
module mag_cmp_cell
  import mag_cmp_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  rel_t rel_i,
  output rel_t rel_o
);
  always_comb begin
    unique case ({a_i, b_i})
      2'b10:   rel_o = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
      2'b01:   rel_o = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
      default: rel_o = rel_i;  // equal bits defer to lower cells
    endcase
  end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output rel_t             rel_o
);
  localparam int unsigned NODES = WIDTH + 1;

  rel_t link [NODES];

  assign link[0] = REL_SEED;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    mag_cmp_cell cell_i (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .rel_i (link[i]),
      .rel_o (link[i+1])
    );
  end

  assign rel_o = link[NODES-1];
endmodule

// File: rtl/mag_cmp_casc.sv
module mag_cmp_casc
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);
  rel_t rel;

  mag_cmp_chain #(.WIDTH(WIDTH)) chain_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .rel_o (rel)
  );

  assign gt_o = rel.gt;
  assign lt_o = rel.lt;
  assign eq_o = rel.eq;
endmodule

// File: rtl/mag_cmp_casc_chk.sv
module mag_cmp_casc_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             gt_o,
  input logic             lt_o,
  input logic             eq_o
);
  always_comb begin
    assert_gt_R1: assert (gt_o == (a_i > b_i));
    assert_lt_R2: assert (lt_o == (a_i < b_i));
    assert_eq_R3: assert (eq_o == (a_i == b_i));
    assert_onehot_R4: assert ($countones({gt_o, lt_o, eq_o}) == 1);
  end
endmodule

bind mag_cmp_casc mag_cmp_casc_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i  (a_i),
  .b_i  (b_i),
  .gt_o (gt_o),
  .lt_o (lt_o),
  .eq_o (eq_o)
);

// File: tb/mag_cmp_casc_tb_top.sv
module mag_cmp_casc_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NW = 4;
  localparam int unsigned WW = 16;
  localparam int unsigned WATCHDOG = 200000;
  localparam int unsigned N_RAND = 2000;

  typedef struct packed {
    logic [WW-1:0] a;
    logic [WW-1:0] b;
    logic [2:0]    exp;  // {gt, lt, eq}
  } vec_t;

  localparam int unsigned N_VEC = 12;
  localparam vec_t VEC [N_VEC] = '{
    '{16'h0000, 16'h0000, 3'b001},
    '{16'hFFFF, 16'hFFFF, 3'b001},
    '{16'h8000, 16'h7FFF, 3'b100},
    '{16'h7FFF, 16'h8000, 3'b010},
    '{16'h0001, 16'h0000, 3'b100},
    '{16'h0000, 16'h0001, 3'b010},
    '{16'hFFFE, 16'hFFFF, 3'b010},
    '{16'hFFFF, 16'hFFFE, 3'b100},
    '{16'h1234, 16'h1234, 3'b001},
    '{16'hA5A5, 16'h5A5A, 3'b100},
    '{16'h00FF, 16'h0100, 3'b010},
    '{16'h8001, 16'h8000, 3'b100}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0] a_n = '0, b_n = '0;
  logic [WW-1:0] a_w = '0, b_w = '0;
  logic gt_n, lt_n, eq_n, gt_w, lt_w, eq_w;
  int unsigned n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mag_cmp_casc #(.WIDTH(NW)) dut_i (
    .a_i(a_n), .b_i(b_n), .gt_o(gt_n), .lt_o(lt_n), .eq_o(eq_n)
  );

  mag_cmp_casc #(.WIDTH(WW)) dut_w_i (
    .a_i(a_w), .b_i(b_w), .gt_o(gt_w), .lt_o(lt_w), .eq_o(eq_w)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a_n=%h b_n=%h a_w=%h b_w=%h got=%b exp=%b",
               req, a_n, b_n, a_w, b_w, got, exp);
    end
  endtask

  function automatic logic [2:0] ref16(input logic [WW-1:0] a, input logic [WW-1:0] b);
    return {a > b, a < b, a == b};
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got=%0d exp<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [2:0] base;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R6 seed with zero operands
    check("R6 zero", {gt_n, lt_n, eq_n}, 3'b001);
    check("R6 zero wide", {gt_w, lt_w, eq_w}, 3'b001);

    // R1 R2 R3 R4 exhaustive narrow
    for (int i = 0; i < (1 << NW); i++) begin
      for (int j = 0; j < (1 << NW); j++) begin
        @(posedge clk);
        a_n = NW'(i);
        b_n = NW'(j);
        @(negedge clk);
        check("R1", {gt_n}, {2'b00, i > j} & 3'b001);
        check("R2", {lt_n}, {2'b00, i < j} & 3'b001);
        check("R3", {eq_n}, {2'b00, i == j} & 3'b001);
        check("R4", 3'($countones({gt_n, lt_n, eq_n})), 3'd1);
      end
    end

    // R5 top differing bit decides
    @(posedge clk); a_n = 4'b1000; b_n = 4'b0111;
    @(negedge clk); check("R5", {gt_n, lt_n, eq_n}, 3'b100);
    @(posedge clk); a_n = 4'b0111; b_n = 4'b1000;
    @(negedge clk); check("R5", {gt_n, lt_n, eq_n}, 3'b010);

    // R6 all-ones on both widths
    @(posedge clk); a_n = '1; b_n = '1; a_w = '1; b_w = '1;
    @(negedge clk);
    check("R6 ones", {gt_n, lt_n, eq_n}, 3'b001);
    check("R6 ones wide", {gt_w, lt_w, eq_w}, 3'b001);

    // R8 wide directed table
    for (int k = 0; k < N_VEC; k++) begin
      @(posedge clk);
      a_w = VEC[k].a;
      b_w = VEC[k].b;
      @(negedge clk);
      check("R8 table", {gt_w, lt_w, eq_w}, VEC[k].exp);
    end

    // R8 wide random
    for (int k = 0; k < N_RAND; k++) begin
      @(posedge clk);
      a_w = WW'($urandom);
      b_w = (k % 4 == 0) ? a_w : WW'($urandom);
      @(negedge clk);
      check("R8 random", {gt_w, lt_w, eq_w}, ref16(a_w, b_w));
    end

    // R7 lower bits cannot alter a decided result
    for (int k = 0; k < 200; k++) begin
      logic [WW-2:0] lo_a, lo_b;
      logic top;
      top = 1'($urandom);
      lo_a = (WW-1)'($urandom);
      lo_b = (WW-1)'($urandom);
      @(posedge clk);
      a_w = {top, lo_a};
      b_w = {~top, lo_b};
      @(negedge clk);
      base = top ? 3'b100 : 3'b010;
      check("R7", {gt_w, lt_w, eq_w}, base);
      @(posedge clk);
      a_w[WW-2:0] = ~lo_a;
      b_w[WW-2:0] = lo_a;
      @(negedge clk);
      check("R7 scrambled", {gt_w, lt_w, eq_w}, base);
    end

    finish_run();
  end
endmodule